// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block combines a byte-wide scratch memory with a calendar clock whose user-visible bytes sit in the top eight locations of a 13-bit byte address space (1FF8h to 1FFFh). A separate set of internal counters keeps time from a timebase tick that is nominally 32,768 Hz. Each time a full second of ticks has elapsed, the counters advance and, unless software has frozen the view, their new values are copied into the visible bytes in that same cycle. This gives software a coherent snapshot.

Software reads the time by setting a freeze bit, reading the bytes at leisure and clearing the bit. To set the time, it raises a write bit, stores new values into the visible bytes and then clears the bit. The clear copies the bytes into the counters and restarts the sub-second divider. Six calibration bits are stored in the control byte and read back, but they do not change the count. All access happens through a synchronous port. A read returns its data one clock after the request.

Top module: `bcd_rtc_window`

## Requirements
- R1: After reset, the control byte reads 00h. Seconds, minutes, hours and year read 00h. Date and month read 01h. The packed day byte reads 01h, which is day 1 in century 0.
- R2: Every address below 1FF8h is plain storage. A write stores the byte, and a read returns it on `rdata_o` one clock after the request. Only the low `RAM_AW` address bits select the storage byte.
- R3: The window layout is fixed. 1FF8h is control, 1FF9h seconds, 1FFAh minutes, 1FFBh hours, and 1FFCh the packed day byte (bits 7:3 century in binary, bits 2:0 day of week). 1FFDh is date, 1FFEh month and 1FFFh year. All fields other than the century are packed BCD.
- R4: Seconds and minutes wrap from 59 to 00 and carry. Hours run in 24-hour form and wrap from 23 to 00. Each BCD digit carries from 9 to the next digit.
- R5: Month lengths follow the calendar: 30 days for months 04, 06, 09 and 11, 31 days for the other months except 02, which has 28 days. In a leap year month 02 has 29 days. A year is a leap year when its two-digit value is divisible by four, and 00 counts as one. After the last date the date returns to 01 and the month advances. After month 12 the month returns to 01.
- R6: The day of week advances at each midnight and wraps from 7 back to 1.
- R7: The year wraps from 99 to 00 and adds one to the 5-bit century, which itself wraps from 31 to 0.
- R8: One second is `TICKS_PER_SEC` clocks with `tick_i` high, counted from the last load. The visible bytes take the advanced time at the clock edge of the final tick.
- R9: Control bit 6 (freeze for reading) and bit 7 (write mode) each stop the once-per-second copy. The internal counters keep running while either bit is set. Bits 5:0 are stored and read back without effect.
- R10: Clearing bit 7 by a write, when it was set, loads the visible bytes into the counters and clears the sub-second divider. The unused upper bits of each field are masked off.
- R11: When a bus write to a visible time byte lands in the same cycle as a second copy, the written value is kept in that byte. The other bytes take the copied time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one clock wide per timebase period |
| cs_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one clock after a read request |

## Verification
A bus write to a clock byte can share an edge with the once-per-second copy into the visible bytes. The bench provokes this by loading a time and giving one tick less than a second. It then issues a minutes write with `tick_i` high in that same cycle. The collision is judged by reading back two bytes. The minutes byte must hold the written value, and the seconds byte must show the advanced second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned WIN_SZ   = 8;
  localparam logic [ADDR_W-1:0] WIN_BASE = 13'h1FF8;

  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_SEC  = 3'd1,
    IDX_MIN  = 3'd2,
    IDX_HOUR = 3'd3,
    IDX_DAY  = 3'd4,
    IDX_DATE = 3'd5,
    IDX_MON  = 3'd6,
    IDX_YEAR = 3'd7
  } win_idx_e;

  localparam int unsigned CTL_WR_BIT = 7;
  localparam int unsigned CTL_RD_BIT = 6;

  typedef struct packed {
    logic [4:0] cent;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [2:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    if (mon == 8'h02)
      r = is_leap(yr) ? 8'h29 : 8'h28;
    else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
      r = 8'h30;
    else
      r = 8'h31;
    return r;
  endfunction

  function automatic logic [7:0] reset_byte(input logic [2:0] idx);
    return (idx == IDX_DAY || idx == IDX_DATE || idx == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign sec_o   = tick_i && at_last && !clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (tick_i)
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t cal_q_o,
  output cal_t cal_d_o
);
  cal_t cur, nxt;

  assign cal_q_o = cur;
  assign cal_d_o = nxt;

  always_comb begin
    nxt = cur;
    if (load_i) begin
      nxt = load_val_i;
    end else if (step_i) begin
      nxt.sec = (cur.sec == 8'h59) ? 8'h00 : bcd_inc(cur.sec);
      if (cur.sec == 8'h59) begin
        nxt.min = (cur.min == 8'h59) ? 8'h00 : bcd_inc(cur.min);
        if (cur.min == 8'h59) begin
          nxt.hour = (cur.hour == 8'h23) ? 8'h00 : bcd_inc(cur.hour);
          if (cur.hour == 8'h23) begin
            nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date == last_date(cur.mon, cur.year)) begin
              nxt.date = 8'h01;
              nxt.mon  = (cur.mon == 8'h12) ? 8'h01 : bcd_inc(cur.mon);
              if (cur.mon == 8'h12) begin
                nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
                if (cur.year == 8'h99)
                  nxt.cent = cur.cent + 5'd1;
              end
            end else begin
              nxt.date = bcd_inc(cur.date);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur      <= '0;
      cur.dow  <= 3'd1;
      cur.date <= 8'h01;
      cur.mon  <= 8'h01;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q, rd_d;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  always_comb begin
    rd_d = rd_q;
    if (re_i) rd_d = mem[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/bcd_rtc_window.sv
module bcd_rtc_window
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned RAM_AW        = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        cs_i,
  input  logic        we_i,
  input  logic [12:0] addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // address decode
  logic win_hit, wr_win, rd_win, ram_we, ram_re;
  assign win_hit = cs_i && (addr_i[ADDR_W-1:3] == WIN_BASE[ADDR_W-1:3]);
  assign wr_win  = win_hit && we_i;
  assign rd_win  = win_hit && !we_i;
  assign ram_we  = cs_i && we_i && !win_hit;
  assign ram_re  = cs_i && !we_i && !win_hit;

  // control byte
  logic [7:0] ctrl_q, ctrl_d;
  logic       ctrl_wr, frozen, load, sec_pulse, xfer;

  assign ctrl_wr = wr_win && (addr_i[2:0] == IDX_CTRL);
  assign frozen  = ctrl_q[CTL_WR_BIT] | ctrl_q[CTL_RD_BIT];
  assign load    = ctrl_wr && ctrl_q[CTL_WR_BIT] && !wdata_i[CTL_WR_BIT];
  assign xfer    = sec_pulse && !frozen;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // timebase and counters
  cal_t cal_q, cal_d, load_val;

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick_i),
    .clr_i  (load),
    .sec_o  (sec_pulse)
  );

  rtc_calendar cal_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .step_i     (sec_pulse),
    .load_i     (load),
    .load_val_i (load_val),
    .cal_q_o    (cal_q),
    .cal_d_o    (cal_d)
  );

  // visible bytes
  logic [WIN_SZ-1:0][7:0] win_rd;
  logic [WIN_SZ-1:1][7:0] xfer_b;

  always_comb begin
    xfer_b[IDX_SEC]  = cal_d.sec;
    xfer_b[IDX_MIN]  = cal_d.min;
    xfer_b[IDX_HOUR] = cal_d.hour;
    xfer_b[IDX_DAY]  = {cal_d.cent, cal_d.dow};
    xfer_b[IDX_DATE] = cal_d.date;
    xfer_b[IDX_MON]  = cal_d.mon;
    xfer_b[IDX_YEAR] = cal_d.year;
  end

  always_comb begin
    load_val      = '0;
    load_val.sec  = win_rd[IDX_SEC]  & 8'h7F;
    load_val.min  = win_rd[IDX_MIN]  & 8'h7F;
    load_val.hour = win_rd[IDX_HOUR] & 8'h3F;
    load_val.dow  = win_rd[IDX_DAY][2:0];
    load_val.cent = win_rd[IDX_DAY][7:3];
    load_val.date = win_rd[IDX_DATE] & 8'h3F;
    load_val.mon  = win_rd[IDX_MON]  & 8'h1F;
    load_val.year = win_rd[IDX_YEAR];
  end

  assign win_rd[IDX_CTRL] = ctrl_q;

  for (genvar gi = 1; gi < WIN_SZ; gi++) begin : g_vis
    logic [7:0] byte_q, byte_d;
    logic       hit;
    assign hit = wr_win && (addr_i[2:0] == 3'(gi));
    always_comb begin
      byte_d = byte_q;
      if (hit)       byte_d = wdata_i;
      else if (xfer) byte_d = xfer_b[gi];
    end
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) byte_q <= reset_byte(3'(gi));
      else        byte_q <= byte_d;
    end
    assign win_rd[gi] = byte_q;
  end

  // storage and read path
  logic [7:0] ram_rdata;

  rtc_byte_store #(.AW(RAM_AW)) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .we_i    (ram_we),
    .re_i    (ram_re),
    .addr_i  (addr_i[RAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (ram_rdata)
  );

  logic       sel_win_q, sel_win_d;
  logic [7:0] win_dat_q, win_dat_d;

  always_comb begin
    sel_win_d = sel_win_q;
    win_dat_d = win_dat_q;
    if (rd_win) begin
      sel_win_d = 1'b1;
      win_dat_d = win_rd[addr_i[2:0]];
    end else if (ram_re) begin
      sel_win_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sel_win_q <= 1'b0;
      win_dat_q <= '0;
    end else begin
      sel_win_q <= sel_win_d;
      win_dat_q <= win_dat_d;
    end
  end

  assign rdata_o = sel_win_q ? win_dat_q : ram_rdata;
endmodule

// File: rtl/bcd_rtc_window_chk.sv
module bcd_rtc_window_chk (
  input logic        clk_i,
  input logic        rst_n,
  input logic        tick_i,
  input logic        cs_i,
  input logic        we_i,
  input logic [12:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        sec_pulse,
  input logic        frozen,
  input logic        load,
  input logic [7:0]  vis_sec,
  input logic [7:0]  cnt_sec,
  input logic [2:0]  cnt_dow
);
  logic wr_sec;
  assign wr_sec = cs_i && we_i && (addr_i == 13'h1FF9);

  // R8
  sec_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    sec_pulse |-> tick_i);

  // R8
  sec_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sec_pulse && !frozen && !wr_sec) |=> (vis_sec == cnt_sec));

  // R9
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (frozen && !wr_sec) |=> $stable(vis_sec));

  // R10
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    load |=> (cnt_sec == ($past(vis_sec) & 8'h7F)));

  // R10
  load_div_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    load |=> !sec_pulse);

  // R6
  dow_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((cnt_dow != 3'd0) && !load) |=> (cnt_dow != 3'd0));

  // R11
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_sec && sec_pulse && !frozen) |=> (vis_sec == $past(wdata_i)));
endmodule

bind bcd_rtc_window bcd_rtc_window_chk chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .sec_pulse (sec_pulse),
  .frozen    (frozen),
  .load      (load),
  .vis_sec   (win_rd[1]),
  .cnt_sec   (cal_q.sec),
  .cnt_dow   (cal_q.dow)
);

// File: tb/bcd_rtc_window_tb_top.sv
module bcd_rtc_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick_i, cs_i, we_i;
  logic [12:0] addr_i;
  logic [7:0]  wdata_i, rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_window #(.TICKS_PER_SEC(TPS), .RAM_AW(8)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cs_i    (cs_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  typedef struct packed {
    logic [7:0] sec, mn, hr, dow, cent, date, mon, yr;
  } tv_t;
  typedef struct packed {
    tv_t st;
    tv_t ex;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{'{8'h59,8'h59,8'h23,8'd7,8'd20,8'h31,8'h12,8'h99}, '{8'h00,8'h00,8'h00,8'd1,8'd21,8'h01,8'h01,8'h00}},
    '{'{8'h59,8'h59,8'h23,8'd3,8'd20,8'h28,8'h02,8'h24}, '{8'h00,8'h00,8'h00,8'd4,8'd20,8'h29,8'h02,8'h24}},
    '{'{8'h59,8'h59,8'h23,8'd3,8'd20,8'h28,8'h02,8'h23}, '{8'h00,8'h00,8'h00,8'd4,8'd20,8'h01,8'h03,8'h23}},
    '{'{8'h59,8'h59,8'h23,8'd4,8'd20,8'h29,8'h02,8'h24}, '{8'h00,8'h00,8'h00,8'd5,8'd20,8'h01,8'h03,8'h24}},
    '{'{8'h59,8'h59,8'h23,8'd2,8'd20,8'h30,8'h04,8'h23}, '{8'h00,8'h00,8'h00,8'd3,8'd20,8'h01,8'h05,8'h23}},
    '{'{8'h59,8'h59,8'h23,8'd2,8'd20,8'h31,8'h01,8'h23}, '{8'h00,8'h00,8'h00,8'd3,8'd20,8'h01,8'h02,8'h23}},
    '{'{8'h09,8'h34,8'h12,8'd5,8'd20,8'h15,8'h06,8'h23}, '{8'h10,8'h34,8'h12,8'd5,8'd20,8'h15,8'h06,8'h23}},
    '{'{8'h59,8'h59,8'h09,8'd5,8'd20,8'h15,8'h06,8'h23}, '{8'h00,8'h00,8'h10,8'd5,8'd20,8'h15,8'h06,8'h23}},
    '{'{8'h59,8'h59,8'h23,8'd6,8'd20,8'h28,8'h02,8'h00}, '{8'h00,8'h00,8'h00,8'd7,8'd20,8'h29,8'h02,8'h00}},
    '{'{8'h59,8'h59,8'h23,8'd6,8'd20,8'h28,8'h02,8'h10}, '{8'h00,8'h00,8'h00,8'd7,8'd20,8'h01,8'h03,8'h10}},
    '{'{8'h59,8'h59,8'h23,8'd1,8'd31,8'h31,8'h12,8'h99}, '{8'h00,8'h00,8'h00,8'd2,8'd0, 8'h01,8'h01,8'h00}},
    '{'{8'h59,8'h59,8'h23,8'd6,8'd20,8'h30,8'h09,8'h19}, '{8'h00,8'h00,8'h00,8'd7,8'd20,8'h01,8'h10,8'h19}}
  };

  function automatic logic [7:0] pack_day(input tv_t t);
    return {t.cent[4:0], t.dow[2:0]};
  endfunction

  function automatic logic [7:0] field_of(input tv_t t, input int idx);
    logic [7:0] r;
    case (idx)
      1: r = t.sec;
      2: r = t.mn;
      3: r = t.hr;
      4: r = pack_day(t);
      5: r = t.date;
      6: r = t.mon;
      default: r = t.yr;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk);
    cs_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk);
    cs_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_i = 1'b1;
    end
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic load_time(input tv_t t);
    wr(13'h1FF8, 8'h80, 1'b0);
    for (int i = 1; i < 8; i++) wr(13'h1FF8 + 13'(i), field_of(t, i), 1'b0);
    wr(13'h1FF8, 8'h00, 1'b0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    tv_t t;
    rst_ni = 1'b0; tick_i = 1'b0; cs_i = 1'b0; we_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(13'h1FF8, d); check("R1 ctrl", d, 8'h00);
    rd(13'h1FF9, d); check("R1 sec", d, 8'h00);
    rd(13'h1FFC, d); check("R1 day", d, 8'h01);
    rd(13'h1FFD, d); check("R1 date", d, 8'h01);
    rd(13'h1FFE, d); check("R1 month", d, 8'h01);
    rd(13'h1FFF, d); check("R1 year", d, 8'h00);

    // R2 plain storage
    wr(13'h0010, 8'h5A, 1'b0);
    wr(13'h1FF7, 8'hC3, 1'b0);
    rd(13'h0010, d); check("R2 low byte", d, 8'h5A);
    rd(13'h1FF7, d); check("R2 top storage byte", d, 8'hC3);
    rd(13'h1FF9, d); check("R2 clock untouched", d, 8'h00);

    // R3 R4 R5 R6 R7 calendar vectors
    for (int v = 0; v < NV; v++) begin
      load_time(VECS[v].st);
      ticks(TPS);
      for (int i = 1; i < 8; i++) begin
        rd(13'h1FF8 + 13'(i), d);
        check($sformatf("R3 R4 R5 R6 R7 vec %0d byte %0d", v, i), d, field_of(VECS[v].ex, i));
      end
    end

    // R8 one second = TPS ticks
    t = '{8'h10, 8'h00, 8'h08, 8'd2, 8'd20, 8'h05, 8'h05, 8'h23};
    load_time(t);
    ticks(TPS - 1);
    rd(13'h1FF9, d); check("R8 before last tick", d, 8'h10);
    ticks(1);
    rd(13'h1FF9, d); check("R8 after last tick", d, 8'h11);

    // R9 freeze for reading, counters keep running, calibration stored
    wr(13'h1FF8, 8'h55, 1'b0);
    ticks(TPS);
    rd(13'h1FF9, d); check("R9 frozen seconds", d, 8'h11);
    rd(13'h1FF8, d); check("R9 calibration readback", d, 8'h55);
    wr(13'h1FF8, 8'h15, 1'b0);
    ticks(TPS);
    rd(13'h1FF9, d); check("R9 counters ran while frozen", d, 8'h13);
    rd(13'h1FF8, d); check("R9 calibration kept", d, 8'h15);

    // R9 R10 write mode holds view, clear loads and restarts divider
    t = '{8'h30, 8'h00, 8'h08, 8'd2, 8'd20, 8'h05, 8'h05, 8'h23};
    load_time(t);
    ticks(TPS - 1);
    wr(13'h1FF8, 8'h80, 1'b0);
    wr(13'h1FF9, 8'h40, 1'b0);
    ticks(TPS);
    rd(13'h1FF9, d); check("R9 write mode holds byte", d, 8'h40);
    wr(13'h1FF8, 8'h00, 1'b0);
    ticks(TPS - 1);
    rd(13'h1FF9, d); check("R10 divider restarted", d, 8'h40);
    ticks(1);
    rd(13'h1FF9, d); check("R10 loaded value counts", d, 8'h41);

    // R11 bus write and second copy in the same cycle
    t = '{8'h20, 8'h05, 8'h08, 8'd2, 8'd20, 8'h05, 8'h05, 8'h23};
    load_time(t);
    ticks(TPS - 1);
    wr(13'h1FFA, 8'h42, 1'b1);
    rd(13'h1FFA, d); check("R11 written byte wins", d, 8'h42);
    rd(13'h1FF9, d); check("R11 other byte copied", d, 8'h21);

    done = 1'b1;
    finish_run();
  end
endmodule